// File: doc/BRIEF.md
# Receive Ring Completion Writer

This block is the receiving end of a descriptor-driven copy channel. Software prepares a ring of descriptors in memory. Each descriptor holds the address of an empty buffer in its first word and a zero completion word in its second. Software then moves a write index forward to hand those buffers to the engine. When a transfer arrives on the inbound stream, the engine fetches the buffer address from the descriptor at its read index. It writes the payload into consecutive words of that buffer and then overwrites the completion word with the received byte count and flags. Only after that write has been acknowledged does it move the read index forward.

A transfer may span many beats; all of them land in one buffer and produce one completion. A nonzero byte count is how software recognises a finished descriptor. Ordering is therefore the central rule: every payload write and the completion write must be acknowledged by memory before the read index changes. The ring size is a power of two, programmed at run time, and a size of zero disables the ring.

Top module: `rcw_rx_completer`

## Requirements
- R1: While reset is high and right after it is released, `rd_idx` is 0, `in_ready` is low and `mem_req_valid` is low.
- R2: When `rd_idx` equals `sw_wr_idx` masked to the ring size, no buffer is posted. In that case `in_ready` stays low, no memory request is issued and `rd_idx` does not move, even while `in_valid` is held high.
- R3: With `cfg_ring_size` equal to 0 the ring is disabled. This holds even when `sw_wr_idx` is nonzero: no beat is accepted and no memory request is issued.
- R4: For each transfer, the engine reads the first descriptor word at `cfg_ring_base + 8*rd_idx` to get the buffer address. It writes beat k of the payload to buffer address + 4*k. A memory request, once raised, holds its address until accepted.
- R5: All beats up to and including the one with `in_last` set form one transfer. Each transfer produces exactly one completion, so `rd_idx` advances by exactly one per transfer.
- R6: The completion word is written to `cfg_ring_base + 8*rd_idx + 4`. Its bits [15:0] hold the byte count, which is 4 times the number of beats and is never zero.
- R7: Bits [23:16] of the completion word carry `in_meta` as sampled on the last beat of the transfer.
- R8: When `cfg_swap_en` is set, or `in_swap` is set for the transfer, every payload word is stored with its four bytes reversed. Bit 30 of the completion word is then set. Otherwise the payload is stored unchanged and bit 30 is clear.
- R9: If the byte count exceeds 65535, bits [15:0] hold 16'hFFFF and bit 31 of the completion word is set. Otherwise bit 31 is clear.
- R10: All payload writes of a transfer are acknowledged before its completion word write is issued. The completion write is acknowledged before `rd_idx` changes.
- R11: `rd_idx` advances as (`rd_idx` + 1) AND (`cfg_ring_size` - 1), wrapping to 0 after the last entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ring_base | input | 32 | Byte address of descriptor 0 |
| cfg_ring_size | input | IDX_W+1 | Number of ring entries, a power of two; 0 disables |
| cfg_swap_en | input | 1 | Reverse bytes of every payload word |
| sw_wr_idx | input | IDX_W | Software post index |
| rd_idx | output | IDX_W | Engine completion index |
| in_valid | input | 1 | Inbound beat valid |
| in_ready | output | 1 | Inbound beat accepted |
| in_data | input | 32 | Inbound payload word |
| in_last | input | 1 | Last beat of a transfer |
| in_meta | input | 8 | Sender metadata, taken on the last beat |
| in_swap | input | 1 | Per-transfer byte reversal request |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | 32 | Byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | One in-order response per request (read data or write acknowledge) |
| mem_rsp_rdata | input | 32 | Read data |

## Verification
The hardest situation to reach is the window between acceptance of the completion write and its acknowledgement. An engine that moves `rd_idx` too early looks correct whenever memory answers at once. The bench memory therefore applies each write only when it returns the acknowledge, and it delays responses and withholds `ready` at random. A monitor samples the descriptor at the moment `rd_idx` moves, so a premature advance exposes a zero completion word. Saturation needs a single transfer of 16384 beats, which the driver streams into one buffer.

// File: rtl/rcw_pkg.sv
package rcw_pkg;

    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 32;
    localparam int LEN_W      = 16;
    localparam int META_W     = 8;
    localparam int FLAG_W     = 16;
    localparam int BEAT_BYTES = DATA_W / 8;
    localparam int DESC_SHIFT = 3;            // 8 bytes per descriptor
    localparam int CMPL_OFS   = 4;            // completion word offset
    localparam int RSVD_W     = FLAG_W - 2 - META_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_FETCH_WAIT,
        ST_STREAM,
        ST_DRAIN,
        ST_WB,
        ST_WB_WAIT
    } rcw_state_e;

    typedef struct packed {
        logic              ovf;
        logic              swapped;
        logic [RSVD_W-1:0] rsvd;
        logic [META_W-1:0] meta;
    } rcw_flags_t;

    typedef struct packed {
        rcw_flags_t       flags;
        logic [LEN_W-1:0] len;
    } rcw_cmpl_t;

    function automatic logic [DATA_W-1:0] byte_rev(input logic [DATA_W-1:0] w);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < BEAT_BYTES; i++) begin
            r[8*i +: 8] = w[DATA_W-8-8*i +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/rcw_ring_index.sv
module rcw_ring_index #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W:0]   cfg_size,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             advance,
    output logic [IDX_W-1:0] rd_idx,
    output logic             empty
);
    localparam int SIZE_W = IDX_W + 1;

    logic [IDX_W-1:0] mask;
    logic             enabled;
    logic [IDX_W-1:0] rd_q;

    assign mask    = IDX_W'(cfg_size - SIZE_W'(1));
    assign enabled = (cfg_size != '0);
    assign empty   = !enabled || (rd_q == (wr_idx & mask));
    assign rd_idx  = rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (advance) begin
            rd_q <= (rd_q + IDX_W'(1)) & mask;
        end
    end
endmodule

// File: rtl/rcw_len_sat.sv
module rcw_len_sat #(
    parameter int LEN_W = 16,
    parameter int STEP  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             add,
    output logic [LEN_W-1:0] len,
    output logic             ovf
);
    logic [LEN_W:0] sum;

    assign sum = {1'b0, len} + (LEN_W+1)'(STEP);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            len <= '0;
            ovf <= 1'b0;
        end else if (add) begin
            if (sum[LEN_W]) begin
                len <= '1;
                ovf <= 1'b1;
            end else begin
                len <= sum[LEN_W-1:0];
            end
        end
    end
endmodule

// File: rtl/rcw_wr_tracker.sv
module rcw_wr_tracker #(
    parameter int MAX_OUTST = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic issue,
    input  logic ack,
    output logic full,
    output logic idle
);
    localparam int CNT_W = $clog2(MAX_OUTST + 1);

    logic [CNT_W-1:0] cnt_q;

    assign full = (cnt_q == CNT_W'(MAX_OUTST));
    assign idle = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            case ({issue, ack})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/rcw_rx_completer.sv
module rcw_rx_completer
    import rcw_pkg::*;
#(
    parameter int IDX_W     = 4,
    parameter int MAX_OUTST = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   cfg_ring_base,
    input  logic [IDX_W:0]      cfg_ring_size,
    input  logic                cfg_swap_en,
    input  logic [IDX_W-1:0]    sw_wr_idx,
    output logic [IDX_W-1:0]    rd_idx,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [DATA_W-1:0]   in_data,
    input  logic                in_last,
    input  logic [META_W-1:0]   in_meta,
    input  logic                in_swap,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic                mem_req_write,
    output logic [ADDR_W-1:0]   mem_req_addr,
    output logic [DATA_W-1:0]   mem_req_wdata,
    input  logic                mem_rsp_valid,
    input  logic [DATA_W-1:0]   mem_rsp_rdata
);
    localparam logic [ADDR_W-1:0] CMPL_OFS_A = ADDR_W'(CMPL_OFS);
    localparam logic [ADDR_W-1:0] BEAT_A     = ADDR_W'(BEAT_BYTES);

    rcw_state_e        st_q, st_d;
    logic [ADDR_W-1:0] buf_ptr_q;
    logic [META_W-1:0] meta_q;
    logic              swap_q;

    logic              ring_empty;
    logic              advance;
    logic              beat_fire;
    logic              swap_now;
    logic              trk_full, trk_idle, trk_ack;
    logic [LEN_W-1:0]  len_cnt;
    logic              len_ovf;
    logic [ADDR_W-1:0] desc_base;
    rcw_cmpl_t         cmpl;
    logic              at_idle;

    // index and occupancy
    rcw_ring_index #(.IDX_W(IDX_W)) ring_i (
        .clk      (clk),
        .rst      (rst),
        .cfg_size (cfg_ring_size),
        .wr_idx   (sw_wr_idx),
        .advance  (advance),
        .rd_idx   (rd_idx),
        .empty    (ring_empty)
    );

    // payload writes in flight
    rcw_wr_tracker #(.MAX_OUTST(MAX_OUTST)) trk_i (
        .clk   (clk),
        .rst   (rst),
        .issue (beat_fire),
        .ack   (trk_ack),
        .full  (trk_full),
        .idle  (trk_idle)
    );

    // byte count with saturation
    rcw_len_sat #(.LEN_W(LEN_W), .STEP(BEAT_BYTES)) len_i (
        .clk   (clk),
        .rst   (rst),
        .clear (at_idle),
        .add   (beat_fire),
        .len   (len_cnt),
        .ovf   (len_ovf)
    );

    assign at_idle   = (st_q == ST_IDLE);
    assign swap_now  = cfg_swap_en | in_swap;
    assign beat_fire = (st_q == ST_STREAM) && in_valid && in_ready;
    assign trk_ack   = mem_rsp_valid && ((st_q == ST_STREAM) || (st_q == ST_DRAIN));
    assign advance   = (st_q == ST_WB_WAIT) && mem_rsp_valid;
    assign desc_base = cfg_ring_base + (ADDR_W'(rd_idx) << DESC_SHIFT);

    always_comb begin
        cmpl               = '0;
        cmpl.len           = len_cnt;
        cmpl.flags.meta    = meta_q;
        cmpl.flags.swapped = swap_q;
        cmpl.flags.ovf     = len_ovf;
    end

    // memory request and inbound ready
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = desc_base;
        mem_req_wdata = '0;
        in_ready      = 1'b0;
        case (st_q)
            ST_FETCH: begin
                mem_req_valid = 1'b1;
            end
            ST_STREAM: begin
                mem_req_valid = in_valid && !trk_full;
                mem_req_write = 1'b1;
                mem_req_addr  = buf_ptr_q;
                mem_req_wdata = swap_now ? byte_rev(in_data) : in_data;
                in_ready      = mem_req_ready && !trk_full;
            end
            ST_WB: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = desc_base + CMPL_OFS_A;
                mem_req_wdata = DATA_W'(cmpl);
            end
            default: ;
        endcase
    end

    // sequencing
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:       if (in_valid && !ring_empty) st_d = ST_FETCH;
            ST_FETCH:      if (mem_req_ready) st_d = ST_FETCH_WAIT;
            ST_FETCH_WAIT: if (mem_rsp_valid) st_d = ST_STREAM;
            ST_STREAM:     if (beat_fire && in_last) st_d = ST_DRAIN;
            ST_DRAIN:      if (trk_idle) st_d = ST_WB;
            ST_WB:         if (mem_req_ready) st_d = ST_WB_WAIT;
            ST_WB_WAIT:    if (mem_rsp_valid) st_d = ST_IDLE;
            default:       st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            buf_ptr_q <= '0;
            meta_q    <= '0;
            swap_q    <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_FETCH_WAIT && mem_rsp_valid) begin
                buf_ptr_q <= mem_rsp_rdata;
            end else if (beat_fire) begin
                buf_ptr_q <= buf_ptr_q + BEAT_A;
            end
            if (beat_fire && in_last) begin
                meta_q <= in_meta;
                swap_q <= swap_now;
            end
        end
    end
endmodule

// File: rtl/rcw_rx_completer_chk.sv
module rcw_rx_completer_chk
    import rcw_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cfg_ring_base,
    input logic [IDX_W:0]    cfg_ring_size,
    input logic [IDX_W-1:0]  sw_wr_idx,
    input logic [IDX_W-1:0]  rd_idx,
    input logic              in_ready,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [DATA_W-1:0] mem_req_wdata,
    input logic              mem_rsp_valid,
    input logic              at_idle,
    input logic              trk_idle
);
    logic [IDX_W-1:0]  mask;
    logic              no_posted;
    logic              cmpl_wr;
    logic [ADDR_W-1:0] cmpl_addr;

    assign mask      = IDX_W'(cfg_ring_size - (IDX_W+1)'(1));
    assign no_posted = (cfg_ring_size == '0) || (rd_idx == (sw_wr_idx & mask));
    assign cmpl_addr = cfg_ring_base + (ADDR_W'(rd_idx) << DESC_SHIFT) + ADDR_W'(CMPL_OFS);
    assign cmpl_wr   = mem_req_valid && mem_req_write && (mem_req_addr == cmpl_addr);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (rd_idx == '0) && !in_ready && !mem_req_valid);

    // R2 R3
    stall_no_buffer_chk: assert property (@(posedge clk) disable iff (rst)
        (at_idle && no_posted) |-> !in_ready && !mem_req_valid);

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr));

    // R6
    len_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        cmpl_wr |-> (mem_req_wdata[LEN_W-1:0] != '0));

    // R9
    ovf_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (cmpl_wr && mem_req_wdata[DATA_W-1]) |-> (mem_req_wdata[LEN_W-1:0] == '1));

    // R10
    data_before_cmpl_chk: assert property (@(posedge clk) disable iff (rst)
        cmpl_wr |-> trk_idle);

    // R10
    idx_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_idx != $past(rd_idx)) |-> $past(mem_rsp_valid));

    // R11
    idx_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_idx != $past(rd_idx)) |-> (rd_idx == (($past(rd_idx) + IDX_W'(1)) & $past(mask))));
endmodule

bind rcw_rx_completer rcw_rx_completer_chk #(.IDX_W(IDX_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .cfg_ring_base (cfg_ring_base),
    .cfg_ring_size (cfg_ring_size),
    .sw_wr_idx     (sw_wr_idx),
    .rd_idx        (rd_idx),
    .in_ready      (in_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .at_idle       (at_idle),
    .trk_idle      (trk_idle)
);

// File: tb/rcw_rx_completer_tb_top.sv
`timescale 1ns/100ps
module rcw_rx_completer_tb_top;

    localparam int IDX_W = 4;
    localparam int BASE  = 32'h0000_1000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [31:0]       cfg_ring_base = BASE;
    logic [IDX_W:0]    cfg_ring_size = '0;
    logic              cfg_swap_en = 1'b0;
    logic [IDX_W-1:0]  sw_wr_idx = '0;
    logic [IDX_W-1:0]  rd_idx;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [31:0]       in_data = '0;
    logic              in_last = 1'b0;
    logic [7:0]        in_meta = '0;
    logic              in_swap = 1'b0;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic              mem_req_write;
    logic [31:0]       mem_req_addr;
    logic [31:0]       mem_req_wdata;
    logic              mem_rsp_valid = 1'b0;
    logic [31:0]       mem_rsp_rdata = '0;

    always #2.5 clk = ~clk;

    rcw_rx_completer #(.IDX_W(IDX_W), .MAX_OUTST(4)) dut_i (
        .clk, .rst, .cfg_ring_base, .cfg_ring_size, .cfg_swap_en, .sw_wr_idx,
        .rd_idx, .in_valid, .in_ready, .in_data, .in_last, .in_meta, .in_swap,
        .mem_req_valid, .mem_req_ready, .mem_req_write, .mem_req_addr,
        .mem_req_wdata, .mem_rsp_valid, .mem_rsp_rdata
    );

    int n_checks = 0;
    int n_fail   = 0;
    int n_cmpl   = 0;
    int n_posted = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // bench memory: writes land only when acknowledged
    logic [31:0] mem [int];
    typedef struct { bit wr; int addr; logic [31:0] data; } req_t;
    req_t pend[$];

    function automatic logic [31:0] mem_rd(input int a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            #0.5;
            mem_rsp_valid = 1'b0;
            if (pend.size() > 0 && ($urandom % 4) != 0) begin
                req_t r;
                r = pend.pop_front();
                if (r.wr) mem[r.addr] = r.data;
                else      mem_rsp_rdata = mem_rd(r.addr);
                mem_rsp_valid = 1'b1;
            end
            mem_req_ready = ($urandom % 4) != 0;
            #1.5;
            if (!rst && mem_req_valid && mem_req_ready) begin
                req_t q;
                q.wr = mem_req_write; q.addr = mem_req_addr; q.data = mem_req_wdata;
                pend.push_back(q);
            end
        end
    end

    // scoreboard
    typedef struct { int slot; int bufa; int nbeats; logic [31:0] word; logic [31:0] first; logic [31:0] last; } exp_t;
    exp_t expq[$];

    function automatic logic [31:0] rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [31:0] pat(input int b, input logic [7:0] m);
        return {m, 8'hA5, 16'(b)};
    endfunction

    // monitor: sample descriptor when the index moves
    initial begin
        logic [IDX_W-1:0] prev;
        prev = '0;
        @(negedge rst);
        forever begin
            @(negedge clk);
            if (rd_idx !== prev) begin
                n_cmpl++;
                if (expq.size() == 0) begin
                    check("R5 unexpected completion", 32'(rd_idx), 32'(prev));
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check("R11 index step", 32'(rd_idx), 32'((e.slot + 1) % 4));
                    check("R6 R7 R9 R10 completion word",
                          mem_rd(BASE + 8*e.slot + 4), e.word);
                    check("R4 R8 first payload word", mem_rd(e.bufa), e.first);
                    check("R4 R8 last payload word",
                          mem_rd(e.bufa + 4*(e.nbeats-1)), e.last);
                end
                prev = rd_idx;
            end
        end
    end

    task automatic post_buf(input int bufa);
        int slot;
        slot = n_posted % 4;
        @(negedge clk);
        mem[BASE + 8*slot]     = bufa;
        mem[BASE + 8*slot + 4] = 32'h0;
        n_posted++;
        sw_wr_idx = sw_wr_idx + 1'b1;
    endtask

    task automatic send(input int slot, input int bufa, input int nbeats,
                        input logic [7:0] meta, input bit swp);
        exp_t e;
        int   bytes;
        bit   sw, ov;
        sw    = swp | cfg_swap_en;
        bytes = 4 * nbeats;
        ov    = bytes > 65535;
        e.slot = slot; e.bufa = bufa; e.nbeats = nbeats;
        e.word  = {ov, sw, 6'b0, meta, (ov ? 16'hFFFF : 16'(bytes))};
        e.first = sw ? rev(pat(0, meta)) : pat(0, meta);
        e.last  = sw ? rev(pat(nbeats-1, meta)) : pat(nbeats-1, meta);
        expq.push_back(e);
        for (int b = 0; b < nbeats; b++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = pat(b, meta);
            in_last  = (b == nbeats - 1);
            in_meta  = (b == nbeats - 1) ? meta : 8'hEE;
            in_swap  = swp;
            forever begin
                #1;
                if (in_ready) break;
                @(negedge clk);
            end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic wait_done();
        while (expq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // hold valid with nothing to take and watch for any reaction
    task automatic stall_probe(input string req);
        bit seen_rdy, seen_req;
        logic [IDX_W-1:0] r0;
        seen_rdy = 0; seen_req = 0;
        r0 = rd_idx;
        @(negedge clk);
        in_valid = 1'b1; in_data = 32'hDEAD_BEEF; in_last = 1'b1;
        repeat (20) begin
            @(negedge clk); #1;
            seen_rdy |= in_ready;
            seen_req |= mem_req_valid;
        end
        check({req, " in_ready stays low"}, 32'(seen_rdy), 32'h0);
        check({req, " no memory request"}, 32'(seen_req), 32'h0);
        check({req, " index unchanged"}, 32'(rd_idx), 32'(r0));
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 rd_idx in reset", 32'(rd_idx), 32'h0);
        check("R1 in_ready in reset", 32'(in_ready), 32'h0);
        rst = 1'b0;
        @(negedge clk); #1;
        check("R1 rd_idx after reset", 32'(rd_idx), 32'h0);
        check("R1 no request after reset", 32'(mem_req_valid), 32'h0);

        // R3: disabled ring ignores posted buffer
        post_buf(32'h0001_0000);
        stall_probe("R3");

        cfg_ring_size = 5'd4;
        send(0, 32'h0001_0000, 3, 8'h11, 1'b0);
        wait_done();

        // R2: nothing posted
        stall_probe("R2");

        post_buf(32'h0002_0000);
        send(1, 32'h0002_0000, 1, 8'h22, 1'b0);
        wait_done();

        // R8 per-transfer swap, gathered R5
        post_buf(32'h0003_0000);
        send(2, 32'h0003_0000, 5, 8'h33, 1'b1);
        wait_done();

        // R8 swap from configuration
        cfg_swap_en = 1'b1;
        post_buf(32'h0004_0000);
        send(3, 32'h0004_0000, 2, 8'h44, 1'b0);
        wait_done();
        cfg_swap_en = 1'b0;

        // R11 wrap to slot 0
        post_buf(32'h0005_0000);
        send(0, 32'h0005_0000, 4, 8'h55, 1'b0);
        wait_done();

        // two posted ahead, back to back
        post_buf(32'h0006_0000);
        post_buf(32'h0007_0000);
        send(1, 32'h0006_0000, 6, 8'h66, 1'b0);
        send(2, 32'h0007_0000, 2, 8'h77, 1'b1);
        wait_done();

        // R9 saturation: 16384 beats = 65536 bytes
        post_buf(32'h0010_0000);
        send(3, 32'h0010_0000, 16384, 8'h88, 1'b0);
        wait_done();

        // R5 one completion per transfer
        check("R5 completion count", 32'(n_cmpl), 32'd8);
        check("R10 index final", 32'(rd_idx), 32'h0);
        report();
    end
endmodule